// File: doc/BRIEF.md
# Shifter and Second-Operand Generator

This block forms the second ALU operand and the shifter carry-out for a 32-bit datapath. It is purely combinational. It reads a 12-bit operand field from the instruction, a select that picks immediate or register form, the value of the register to be shifted, the value of the register that may supply a shift amount, and the current carry flag. The register file, the ALU, the flag register and instruction fetch all sit outside it.

In immediate form the block widens an 8-bit constant and rotates it right by twice a 4-bit rotate field. In register form it applies a logical left shift, a logical right shift, an arithmetic right shift, a right rotation or a one-bit rotation through carry to the source value. The shift amount comes from a 5-bit field or from the low byte of the amount register. Every mode and every amount, including 0, 32 and amounts above 32, gives a defined result and a defined carry-out. The ALU can therefore use the carry-out directly when the operation is a logical one that updates flags.

Top module: `opnd_shifter_top`

## Requirements
- R1: With `sel_imm`=1, `operand_out` is the 8-bit constant `op_field[7:0]`, zero-extended to 32 bits and rotated right by 2×`op_field[11:8]` positions (even rotations from 0 to 30).
- R2: In immediate form, a rotate field of 0 gives `carry_out`=`carry_in`. A nonzero rotate field gives `carry_out` equal to bit 31 of the rotated constant.
- R3: With `sel_imm`=0, the field is decoded as follows. `op_field[6:5]` is the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `op_field[4]`=0 takes the amount from `op_field[11:7]`. `op_field[4]`=1 takes it from `amt_reg[7:0]`. `op_field[3:0]` has no effect on either output.
- R4: A logical left shift fills with zeros, and the carry-out is the last bit shifted out of bit 31. A field amount of 0 passes `src_val` through with `carry_out`=`carry_in`.
- R5: A logical right shift fills with zeros, and the carry-out is the last bit shifted out of bit 0. A field amount of 0 means 32 and gives 0 with carry-out `src_val[31]`.
- R6: An arithmetic right shift fills with copies of `src_val[31]`, and the carry-out is the last bit shifted out of bit 0. A field amount of 0 means 32, which sets every result bit and the carry-out to `src_val[31]`.
- R7: A right rotation by a nonzero field amount wraps the bits leaving bit 0 into bit 31, and the carry-out is the last bit rotated out. A field amount of 0 selects rotate-through-carry: the result is {`carry_in`, `src_val[31:1]`} and the carry-out is `src_val[0]`.
- R8: When the amount comes from the register and `amt_reg[7:0]` is 0, every kind passes `src_val` through with `carry_out`=`carry_in`. `amt_reg[31:8]` never has an effect.
- R9: For register amounts, a logical left or right shift by exactly 32 gives 0 with carry-out `src_val[0]` (left) or `src_val[31]` (right). Amounts above 32 give 0 with carry-out 0. An arithmetic right shift by 32 or more gives a full sign fill with carry-out `src_val[31]`.
- R10: A register-amount right rotation by a nonzero amount rotates by the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged, with carry-out `src_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_imm | input | 1 | 1 selects the rotated-constant form, 0 the shifted-register form |
| op_field | input | 12 | Operand field of the instruction |
| src_val | input | 32 | Value of the register to be shifted |
| amt_reg | input | 32 | Value of the register that may supply the shift amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Directed patterns come first. Single set bits at the two edges of the word tell a shift from a rotation and show which edge bit reaches the carry. Values with the top bit set tell arithmetic fill from logical fill. Rotated constants whose ones land in bit 31, or stay clear of it, tell the two immediate carry rules apart. Register amounts of 0, 32, 33, 36, 64, 100, 200 and 256 separate the pass-through case, the exact-width case, the over-width case and the modulo rotation. A long run of pseudo-random fields, values, amounts and carries follows, including set bits in the ignored field positions and in the upper amount-register bits, and every cycle is compared with a bit-serial reference.

// File: rtl/opnd_shift_pkg.sv
`timescale 1ns/1ps
package opnd_shift_pkg;

  localparam int AMT_BYTE_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  // Normalised shift request: the amount is already the effective one
  // (field zero mapped to 32 where needed), and rrx flags rotate-through-carry.
  typedef struct packed {
    shift_kind_e           kind;
    logic [AMT_BYTE_W-1:0] amt;
    logic                  rrx;
  } shift_req_t;

endpackage

// File: rtl/opnd_ror.sv
`timescale 1ns/1ps
module opnd_ror #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [SW+1];

  assign stage[0] = din;

  // Logarithmic rotator: stage k rotates right by 2**k when amt[k] is set.
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]} : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/opnd_imm_rotator.sv
`timescale 1ns/1ps
module opnd_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              carry_in,
  output logic [DATA_W-1:0] value,
  output logic              carry
);

  localparam int SW = $clog2(DATA_W);

  logic [DATA_W-1:0] widened;
  logic [SW-1:0]     rot_amt;

  assign widened = {{(DATA_W-IMM_W){1'b0}}, imm};
  assign rot_amt = SW'({rot, 1'b0});

  opnd_ror #(.W(DATA_W), .SW(SW)) u_rot (
    .din  (widened),
    .amt  (rot_amt),
    .dout (value)
  );

  always_comb begin
    carry = (rot == '0) ? carry_in : value[DATA_W-1];
  end

  // R1: a rotation neither creates nor loses ones
  always_comb begin
    a_r1_imm_ones_kept: assert ($countones(value) == $countones(imm))
      else $error("R1 immediate rotation changed the number of ones");
  end

endmodule

// File: rtl/opnd_amount_sel.sv
`timescale 1ns/1ps
module opnd_amount_sel
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FLD_AMT_W = 5
) (
  input  logic [FLD_AMT_W-1:0]  fld_amt,
  input  logic [1:0]            kind_code,
  input  logic                  from_reg,
  input  logic [AMT_BYTE_W-1:0] reg_byte,
  output shift_req_t            req
);

  localparam logic [AMT_BYTE_W-1:0] FULL_WIDTH = AMT_BYTE_W'(DATA_W);

  always_comb begin
    req.kind = shift_kind_e'(kind_code);
    req.rrx  = 1'b0;
    req.amt  = '0;
    if (from_reg) begin
      req.amt = reg_byte;
    end else if (fld_amt == '0) begin
      unique case (req.kind)
        SH_LSL:         req.amt = '0;
        SH_LSR, SH_ASR: req.amt = FULL_WIDTH;
        SH_ROR:         req.rrx = 1'b1;
        default:        req.amt = '0;
      endcase
    end else begin
      req.amt = AMT_BYTE_W'(fld_amt);
    end
  end

endmodule

// File: rtl/opnd_barrel.sv
`timescale 1ns/1ps
module opnd_barrel
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shift_req_t        req,
  input  logic [DATA_W-1:0] src,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry
);

  localparam int SW = $clog2(DATA_W);

  logic [DATA_W:0]        lsl_wide;
  logic [DATA_W:0]        lsr_wide;
  logic signed [DATA_W:0] asr_wide;
  logic [DATA_W-1:0]      ror_val;

  // One guard bit beyond the word catches the last bit shifted out.
  assign lsl_wide = {1'b0, src} << req.amt;
  assign lsr_wide = {src, 1'b0} >> req.amt;
  assign asr_wide = $signed({src, 1'b0}) >>> req.amt;

  opnd_ror #(.W(DATA_W), .SW(SW)) u_ror (
    .din  (src),
    .amt  (req.amt[SW-1:0]),
    .dout (ror_val)
  );

  always_comb begin
    res   = src;
    carry = carry_in;
    if (req.rrx) begin
      res   = {carry_in, src[DATA_W-1:1]};
      carry = src[0];
    end else if (req.amt != '0) begin
      unique case (req.kind)
        SH_LSL: begin res = lsl_wide[DATA_W-1:0]; carry = lsl_wide[DATA_W]; end
        SH_LSR: begin res = lsr_wide[DATA_W:1];   carry = lsr_wide[0];      end
        SH_ASR: begin res = asr_wide[DATA_W:1];   carry = asr_wide[0];      end
        SH_ROR: begin res = ror_val;              carry = ror_val[DATA_W-1]; end
        default: begin res = src; carry = carry_in; end
      endcase
    end
  end

  always_comb begin
    if (!req.rrx && req.amt != '0 && req.kind == SH_LSR) begin
      a_r5_lsr_top_zero: assert (res[DATA_W-1] == 1'b0)
        else $error("R5 logical right shift left a one in the top bit");
    end
    if (!req.rrx && req.kind == SH_ASR) begin
      a_r6_asr_sign_kept: assert (res[DATA_W-1] == src[DATA_W-1])
        else $error("R6 arithmetic right shift lost the sign");
    end
    if (!req.rrx && req.kind == SH_ROR) begin
      a_r10_ror_ones_kept: assert ($countones(res) == $countones(src))
        else $error("R10 rotation changed the number of ones");
    end
    if (!req.rrx && (req.kind == SH_LSL || req.kind == SH_LSR) && req.amt > DATA_W) begin
      a_r9_wide_shift_zero: assert (res == '0 && carry == 1'b0)
        else $error("R9 over-width logical shift not cleared");
    end
  end

endmodule

// File: rtl/opnd_shifter_top.sv
`timescale 1ns/1ps
module opnd_shifter_top
  import opnd_shift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int FLD_AMT_W = 5,
  parameter int FIELD_W   = IMM_W + ROT_W
) (
  input  logic               sel_imm,
  input  logic [FIELD_W-1:0] op_field,
  input  logic [DATA_W-1:0]  src_val,
  input  logic [DATA_W-1:0]  amt_reg,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  operand_out,
  output logic               carry_out
);

  localparam int AMT_LSB  = FIELD_W - FLD_AMT_W;
  localparam int KIND_LSB = AMT_LSB - 2;
  localparam int SRC_BIT  = KIND_LSB - 1;

  logic [DATA_W-1:0] imm_val;
  logic              imm_carry;
  logic [DATA_W-1:0] sh_val;
  logic              sh_carry;
  shift_req_t        req;
  logic              unused_bits;

  assign unused_bits = ^{op_field[SRC_BIT-1:0], amt_reg[DATA_W-1:AMT_BYTE_W]};

  opnd_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm      (op_field[IMM_W-1:0]),
    .rot      (op_field[FIELD_W-1:IMM_W]),
    .carry_in (carry_in),
    .value    (imm_val),
    .carry    (imm_carry)
  );

  opnd_amount_sel #(.DATA_W(DATA_W), .FLD_AMT_W(FLD_AMT_W)) u_amt (
    .fld_amt   (op_field[FIELD_W-1:AMT_LSB]),
    .kind_code (op_field[AMT_LSB-1:KIND_LSB]),
    .from_reg  (op_field[SRC_BIT]),
    .reg_byte  (amt_reg[AMT_BYTE_W-1:0]),
    .req       (req)
  );

  opnd_barrel #(.DATA_W(DATA_W)) u_barrel (
    .req      (req),
    .src      (src_val),
    .carry_in (carry_in),
    .res      (sh_val),
    .carry    (sh_carry)
  );

  always_comb begin
    operand_out = sel_imm ? imm_val   : sh_val;
    carry_out   = sel_imm ? imm_carry : sh_carry;
  end

  always_comb begin
    if (!sel_imm && op_field[SRC_BIT] && amt_reg[AMT_BYTE_W-1:0] == '0) begin
      a_r8_zero_reg_amount_passes: assert (operand_out == src_val && carry_out == carry_in)
        else $error("R8 zero register amount did not pass through");
    end
    if (!sel_imm && !op_field[SRC_BIT] && op_field[AMT_LSB-1:KIND_LSB] == 2'b11
        && op_field[FIELD_W-1:AMT_LSB] == '0) begin
      a_r7_rrx_edges: assert (operand_out[DATA_W-1] == carry_in && carry_out == src_val[0])
        else $error("R7 rotate-through-carry edges wrong");
    end
  end

endmodule

// File: tb/opnd_shifter_top_test.sv
`timescale 1ns/1ps
module opnd_shifter_top_test;

  logic        clk;
  logic        rst_n;
  logic        sel_imm;
  logic [11:0] op_field;
  logic [31:0] src_val;
  logic [31:0] amt_reg;
  logic        carry_in;
  logic [31:0] operand_out;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  opnd_shifter_top uut (
    .sel_imm     (sel_imm),
    .op_field    (op_field),
    .src_val     (src_val),
    .amt_reg     (amt_reg),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Bit-serial reference: one single-bit step per unit of amount.
  function automatic void ref_model(input logic sel, input logic [11:0] f,
                                    input logic [31:0] v, input logic [31:0] ar,
                                    input logic cin,
                                    output logic [31:0] r, output logic c);
    int n;
    int kind;
    r = v;
    c = cin;
    if (sel) begin
      int rot;
      rot = 2 * int'(f[11:8]);
      r = {24'd0, f[7:0]};
      for (int i = 0; i < rot; i++) r = {r[0], r[31:1]};
      if (rot != 0) c = r[31];
      return;
    end
    kind = int'(f[6:5]);
    if (f[4]) n = int'(ar[7:0]);
    else if (f[11:7] != 0) n = int'(f[11:7]);
    else if (kind == 1 || kind == 2) n = 32;
    else if (kind == 3) begin
      r = {cin, v[31:1]};
      c = v[0];
      return;
    end else n = 0;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  function automatic logic [11:0] reg_fld(input int amt, input int kind, input bit from_reg);
    return {5'(amt), 2'(kind), from_reg, 4'b0000};
  endfunction

  task automatic compare(input string tag);
    logic [31:0] er;
    logic        ec;
    ref_model(sel_imm, op_field, src_val, amt_reg, carry_in, er, ec);
    checks++;
    if (operand_out !== er || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: got operand %h carry %b, expected operand %h carry %b",
               tag, operand_out, carry_out, er, ec);
    end
  endtask

  task automatic apply(input logic s, input logic [11:0] f, input logic [31:0] v,
                       input logic [31:0] ar, input logic cin, input string tag);
    @(posedge clk);
    sel_imm  = s;
    op_field = f;
    src_val  = v;
    amt_reg  = ar;
    carry_in = cin;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n    = 1'b0;
    sel_imm  = 1'b0;
    op_field = '0;
    src_val  = '0;
    amt_reg  = '0;
    carry_in = 1'b0;
    repeat (2) @(negedge clk);
    compare("R4 idle zero inputs");
    rst_n = 1'b1;

    // R1 / R2 rotated constants
    apply(1, {4'd0,  8'hFF}, 32'h0, 32'h0, 1'b1, "R1 R2 rot0 keeps carry");
    apply(1, {4'd13, 8'h40}, 32'h0, 32'h0, 1'b1, "R1 0x40 ror 26 = 0x1000");
    apply(1, {4'd1,  8'h81}, 32'h0, 32'h0, 1'b1, "R2 ror2 bit31 clear carry 0");
    apply(1, {4'd1,  8'h03}, 32'h0, 32'h0, 1'b0, "R2 ror2 bit31 set carry 1");
    // R4 logical left
    apply(0, reg_fld(4, 0, 0), 32'hF000000F, 32'h0, 1'b0, "R4 lsl 4");
    apply(0, reg_fld(0, 0, 0), 32'hDEADBEEF, 32'h0, 1'b1, "R4 lsl 0 passes");
    // R5 logical right
    apply(0, reg_fld(1, 1, 0), 32'h80000001, 32'h0, 1'b0, "R5 lsr 1");
    apply(0, reg_fld(0, 1, 0), 32'h80000000, 32'h0, 1'b0, "R5 lsr field0 means 32");
    // R6 arithmetic right
    apply(0, reg_fld(4, 2, 0), 32'h80000010, 32'h0, 1'b1, "R6 asr 4");
    apply(0, reg_fld(0, 2, 0), 32'h80000000, 32'h0, 1'b0, "R6 asr field0 means 32");
    // R7 rotate / rotate-through-carry
    apply(0, reg_fld(8, 3, 0), 32'h12345678, 32'h0, 1'b1, "R7 ror 8");
    apply(0, reg_fld(0, 3, 0), 32'h00000003, 32'h0, 1'b1, "R7 rrx with carry 1");
    apply(0, reg_fld(0, 3, 0), 32'h80000002, 32'h0, 1'b0, "R7 rrx with carry 0");
    // R3 ignored low field bits
    apply(0, reg_fld(4, 0, 0) | 12'h00F, 32'h0F0F0F0F, 32'h0, 1'b0, "R3 low field bits ignored");
    // R8 zero register amount, upper amount bits ignored
    apply(0, reg_fld(0, 2, 1), 32'h80000001, 32'h00000100, 1'b1, "R8 asr reg 256 passes");
    apply(0, reg_fld(0, 0, 1), 32'h12345678, 32'hFFFFFF00, 1'b0, "R8 lsl reg 0 passes");
    // R9 wide register amounts
    apply(0, reg_fld(0, 0, 1), 32'h00000001, 32'd32,  1'b0, "R9 lsl reg 32");
    apply(0, reg_fld(0, 0, 1), 32'hFFFFFFFF, 32'd33,  1'b1, "R9 lsl reg 33");
    apply(0, reg_fld(0, 1, 1), 32'h80000000, 32'd32,  1'b0, "R9 lsr reg 32");
    apply(0, reg_fld(0, 1, 1), 32'hFFFFFFFF, 32'd200, 1'b1, "R9 lsr reg 200");
    apply(0, reg_fld(0, 2, 1), 32'h80000000, 32'd100, 1'b0, "R9 asr reg 100");
    apply(0, reg_fld(0, 2, 1), 32'h7FFFFFFF, 32'd40,  1'b1, "R9 asr reg 40 positive");
    // R10 register rotation
    apply(0, reg_fld(0, 3, 1), 32'h0000000F, 32'd36, 1'b0, "R10 ror reg 36");
    apply(0, reg_fld(0, 3, 1), 32'h80000000, 32'd64, 1'b0, "R10 ror reg 64");

    // Pseudo-random sweep, compared every clock
    for (int i = 0; i < 3000; i++) begin
      logic s;
      logic [11:0] f;
      logic [31:0] ar;
      string tag;
      s  = ($urandom % 4) == 0;
      f  = 12'($urandom);
      ar = $urandom;
      if (($urandom % 3) == 0) ar[7:0] = 8'(($urandom % 3) * 32 + ($urandom % 2));
      if (s) tag = "R1 R2 random immediate";
      else if (f[4]) tag = "R9 R10 random register amount";
      else tag = "R3 random field amount";
      apply(s, f, $urandom, ar, 1'($urandom), tag);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule